// File: doc/BRIEF.md
# Banked DRAM Request Scheduler

This block holds pending read and write requests for one DRAM channel and picks, each cycle, the next request to send to the command sequencer. Requests arrive one at a time with a target bank, row and column and a read/write flag. Each is written into a small queue belonging to its bank and stamped with the value of a free-running arrival counter. Because requests are kept per bank, two requests to the same bank can leave in a different order from the one in which they arrived.

The choice depends on two inputs for each bank: whether the bank is busy, and which row its row buffer currently holds. A mode input selects between two policies. In strict arrival order, only the oldest request is considered. In the hit-first policy, requests to the open row go ahead of older requests that need a row change, and requests to busy banks are passed over. Reads go ahead of writes. Writes collect in the queues until no read remains, or until so many writes are pending that the block switches to draining them. The chosen request is held on the issue port until the sequencer accepts it, and its queue slot is freed in that same cycle.

Top module: `fr_sched`

## Requirements
- R1: After reset no request is pending: `iss_valid_o` is 0 and `req_ready_o` is 1 for every bank.
- R2: A request is stored when `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 exactly when the bank named by `req_bank_i` already holds DEPTH requests.
- R3: With `mode_i`=0 (arrival order), the candidate is the oldest pending request of the preferred type. `iss_valid_o` is 1 only if that request's bank is not busy.
- R4: With `mode_i`=1 (hit-first), a request is a row hit when `row_open_i[b]` is 1 and its row equals slice b of `open_row_i` (bits b*ROW_W upward). A row hit is chosen over any row miss, even an older one.
- R5: Among requests that share a hit class and are all eligible, the one accepted earliest is chosen.
- R6: With `mode_i`=1, requests to a bank whose `bank_busy_i` bit is 1 are skipped, and the next candidate in priority order is issued instead.
- R7: When not draining, a write is never issued while any read is pending. Writes become candidates only once no read is pending.
- R8: The drain flag is set when the count of pending writes, taken after a cycle's accept and issue, reaches WR_HI. It is cleared when that count falls below WR_LO. While the flag is set, only writes are candidates.
- R9: A request leaves its queue only in a cycle with `iss_valid_o`=1 and `iss_ready_i`=1. While `iss_ready_i` is 0 the request stays pending.
- R10: `iss_wr_o`, `iss_bank_o`, `iss_row_o` and `iss_col_o` carry the flag and address of the chosen request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: arrival order, 1: hit-first |
| req_valid_i | input | 1 | Incoming request present |
| req_ready_o | output | 1 | Target bank queue has room |
| req_wr_i | input | 1 | 1: write, 0: read |
| req_bank_i | input | $clog2(NB) | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| bank_busy_i | input | NB | Bank cannot take a command |
| row_open_i | input | NB | Bank has an open row |
| open_row_i | input | NB*ROW_W | Open row of each bank |
| iss_valid_o | output | 1 | Chosen request present |
| iss_ready_i | input | 1 | Sequencer takes the request |
| iss_wr_o | output | 1 | Chosen request is a write |
| iss_bank_o | output | $clog2(NB) | Chosen bank |
| iss_row_o | output | ROW_W | Chosen row |
| iss_col_o | output | COL_W | Chosen column |

## Verification
The bench builds the block with four banks, two slots per bank, two-bit rows, and write watermarks of 4 and 2. With these values, full bank queues, drain entry and drain exit all occur often within a few thousand cycles of random traffic. Rows are drawn mostly from the open row, so row hits and misses appear mixed in the queues. The age stamp is set to 16 bits so that ordering can be compared directly against a running sequence number. Busy banks, open rows, the policy mode and back-pressure on the issue port are all varied while requests are pending.

// File: rtl/fr_sched_pkg.sv
package fr_sched_pkg;
  typedef enum logic {
    SCHED_ARRIVAL = 1'b0,
    SCHED_HIT_FIRST = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/fr_bank_queue.sv
module fr_bank_queue #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int AGE_W = 8,
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_i,
  input  logic                   alloc_wr_i,
  input  logic [ROW_W-1:0]       alloc_row_i,
  input  logic [COL_W-1:0]       alloc_col_i,
  input  logic [AGE_W-1:0]       alloc_age_i,
  input  logic                   free_i,
  input  logic [SW-1:0]          free_slot_i,
  output logic                   full_o,
  output logic [DEPTH-1:0]       vld_o,
  output logic [DEPTH-1:0]       wr_o,
  output logic [DEPTH*ROW_W-1:0] row_o,
  output logic [DEPTH*COL_W-1:0] col_o,
  output logic [DEPTH*AGE_W-1:0] age_o
);
  logic [DEPTH-1:0]             vld_q, wr_q;
  logic [DEPTH-1:0][ROW_W-1:0]  row_q;
  logic [DEPTH-1:0][COL_W-1:0]  col_q;
  logic [DEPTH-1:0][AGE_W-1:0]  age_q;
  logic [SW-1:0]                slot;

  // lowest free slot
  always_comb begin
    slot   = '0;
    full_o = 1'b1;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (!vld_q[s]) begin
        slot   = SW'(s);
        full_o = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      row_q <= '0;
      col_q <= '0;
      age_q <= '0;
    end else begin
      if (free_i) vld_q[free_slot_i] <= 1'b0;
      if (alloc_i) begin
        vld_q[slot] <= 1'b1;
        wr_q[slot]  <= alloc_wr_i;
        row_q[slot] <= alloc_row_i;
        col_q[slot] <= alloc_col_i;
        age_q[slot] <= alloc_age_i;
      end
    end
  end

  assign vld_o = vld_q;
  assign wr_o  = wr_q;
  assign row_o = row_q;
  assign col_o = col_q;
  assign age_o = age_q;

  AST_FREE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> vld_q[free_slot_i]); // R9
  AST_ALLOC_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o); // R2
endmodule

// File: rtl/fr_picker.sv
module fr_picker #(
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int AGE_W = 8,
  localparam int N  = NB * DEPTH,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fr_sched_pkg::sched_mode_e mode_i,
  input  logic                pref_wr_i,
  input  logic [AGE_W-1:0]    age_now_i,
  input  logic [N-1:0]        vld_i,
  input  logic [N-1:0]        wr_i,
  input  logic [N*ROW_W-1:0]  row_i,
  input  logic [N*AGE_W-1:0]  age_i,
  input  logic [NB-1:0]       bank_busy_i,
  input  logic [NB-1:0]       row_open_i,
  input  logic [NB*ROW_W-1:0] open_row_i,
  output logic                sel_vld_o,
  output logic [BW-1:0]       sel_bank_o,
  output logic [SW-1:0]       sel_slot_o
);
  import fr_sched_pkg::*;

  logic          fr;
  logic          found;
  logic [AGE_W:0] best_key;

  assign fr = (mode_i == SCHED_HIT_FIRST);

  // key = {row hit, distance from arrival counter}; larger wins
  always_comb begin
    found      = 1'b0;
    best_key   = '0;
    sel_bank_o = '0;
    sel_slot_o = '0;
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < DEPTH; s++) begin : g_ent
        logic [AGE_W-1:0] rel;
        logic             hit;
        logic             elig;
        logic [AGE_W:0]   key;
        rel  = age_now_i - age_i[(b*DEPTH+s)*AGE_W +: AGE_W];
        hit  = fr && row_open_i[b] &&
               (row_i[(b*DEPTH+s)*ROW_W +: ROW_W] == open_row_i[b*ROW_W +: ROW_W]);
        key  = {hit, rel};
        elig = vld_i[b*DEPTH+s] && (wr_i[b*DEPTH+s] == pref_wr_i) &&
               !(fr && bank_busy_i[b]);
        if (elig && (!found || key > best_key)) begin
          found      = 1'b1;
          best_key   = key;
          sel_bank_o = BW'(b);
          sel_slot_o = SW'(s);
        end
      end
    end
    sel_vld_o = found && !bank_busy_i[sel_bank_o];
  end

  AST_SEL_PREF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_vld_o |-> (vld_i[int'(sel_bank_o)*DEPTH + int'(sel_slot_o)] &&
                   wr_i[int'(sel_bank_o)*DEPTH + int'(sel_slot_o)] == pref_wr_i)); // R3
endmodule

// File: rtl/fr_sched.sv
module fr_sched #(
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int AGE_W = 8,
  parameter int WR_HI = 8,
  parameter int WR_LO = 4,
  localparam int N     = NB * DEPTH,
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1,
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_wr_i,
  input  logic [BW-1:0]       req_bank_i,
  input  logic [ROW_W-1:0]    req_row_i,
  input  logic [COL_W-1:0]    req_col_i,
  input  logic [NB-1:0]       bank_busy_i,
  input  logic [NB-1:0]       row_open_i,
  input  logic [NB*ROW_W-1:0] open_row_i,
  output logic                iss_valid_o,
  input  logic                iss_ready_i,
  output logic                iss_wr_o,
  output logic [BW-1:0]       iss_bank_o,
  output logic [ROW_W-1:0]    iss_row_o,
  output logic [COL_W-1:0]    iss_col_o
);
  import fr_sched_pkg::*;

  logic [N-1:0]       vld_all, wr_all;
  logic [N*ROW_W-1:0] row_all;
  logic [N*COL_W-1:0] col_all;
  logic [N*AGE_W-1:0] age_all;
  logic [NB-1:0]      full;
  logic [AGE_W-1:0]   age_q;
  logic [CW-1:0]      wr_cnt_q, rd_cnt_q, wr_cnt_d, rd_cnt_d;
  logic               drain_q, drain_d;
  logic               pref_wr;
  logic               req_fire, iss_fire;
  logic [BW-1:0]      sel_bank;
  logic [SW-1:0]      sel_slot;
  logic               sel_vld;
  int                 sel_idx;

  assign req_ready_o = !full[req_bank_i];
  assign req_fire    = req_valid_i && req_ready_o;
  assign iss_fire    = iss_valid_o && iss_ready_i;
  assign pref_wr     = drain_q || (rd_cnt_q == '0);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    fr_bank_queue #(
      .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)
    ) u_q (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (req_fire && (req_bank_i == BW'(b))),
      .alloc_wr_i  (req_wr_i),
      .alloc_row_i (req_row_i),
      .alloc_col_i (req_col_i),
      .alloc_age_i (age_q),
      .free_i      (iss_fire && (sel_bank == BW'(b))),
      .free_slot_i (sel_slot),
      .full_o      (full[b]),
      .vld_o       (vld_all[b*DEPTH +: DEPTH]),
      .wr_o        (wr_all[b*DEPTH +: DEPTH]),
      .row_o       (row_all[b*DEPTH*ROW_W +: DEPTH*ROW_W]),
      .col_o       (col_all[b*DEPTH*COL_W +: DEPTH*COL_W]),
      .age_o       (age_all[b*DEPTH*AGE_W +: DEPTH*AGE_W])
    );
  end

  fr_picker #(
    .NB(NB), .DEPTH(DEPTH), .ROW_W(ROW_W), .AGE_W(AGE_W)
  ) u_pick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (sched_mode_e'(mode_i)),
    .pref_wr_i   (pref_wr),
    .age_now_i   (age_q),
    .vld_i       (vld_all),
    .wr_i        (wr_all),
    .row_i       (row_all),
    .age_i       (age_all),
    .bank_busy_i (bank_busy_i),
    .row_open_i  (row_open_i),
    .open_row_i  (open_row_i),
    .sel_vld_o   (sel_vld),
    .sel_bank_o  (sel_bank),
    .sel_slot_o  (sel_slot)
  );

  always_comb begin
    sel_idx     = int'(sel_bank) * DEPTH + int'(sel_slot);
    iss_valid_o = sel_vld;
    iss_bank_o  = sel_bank;
    iss_wr_o    = wr_all[sel_idx];
    iss_row_o   = row_all[sel_idx*ROW_W +: ROW_W];
    iss_col_o   = col_all[sel_idx*COL_W +: COL_W];
  end

  // occupancy by type and write-drain hysteresis
  always_comb begin
    wr_cnt_d = wr_cnt_q + CW'(req_fire && req_wr_i) - CW'(iss_fire && iss_wr_o);
    rd_cnt_d = rd_cnt_q + CW'(req_fire && !req_wr_i) - CW'(iss_fire && !iss_wr_o);
    if (wr_cnt_d >= CW'(WR_HI))      drain_d = 1'b1;
    else if (wr_cnt_d < CW'(WR_LO))  drain_d = 1'b0;
    else                             drain_d = drain_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q    <= '0;
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
      drain_q  <= 1'b0;
    end else begin
      if (req_fire) age_q <= age_q + 1'b1;
      wr_cnt_q <= wr_cnt_d;
      rd_cnt_q <= rd_cnt_d;
      drain_q  <= drain_d;
    end
  end

  AST_ISS_BANK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> !bank_busy_i[iss_bank_o]); // R6
  AST_WR_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_wr_o && !drain_q) |-> (rd_cnt_q == '0)); // R7
  AST_DRAIN_ONLY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && drain_q) |-> iss_wr_o); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rd_cnt_q) + 32'(wr_cnt_q)) <= N); // R2
  AST_ISS_IMPLIES_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (rd_cnt_q != '0 || wr_cnt_q != '0)); // R9
endmodule

// File: tb/fr_sched_tb_top.sv
`timescale 1ns/1ps
module fr_sched_tb_top;
  localparam int NB = 4, DEPTH = 2, ROW_W = 2, COL_W = 3, AGE_W = 16;
  localparam int WR_HI = 4, WR_LO = 2, CAP = NB * DEPTH;
  localparam int CYCLES = 4000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode, req_valid, req_ready, req_wr, iss_valid, iss_ready, iss_wr;
  logic [1:0] req_bank, iss_bank;
  logic [ROW_W-1:0] req_row, iss_row;
  logic [COL_W-1:0] req_col, iss_col;
  logic [NB-1:0] busy, ropen;
  logic [NB*ROW_W-1:0] orow;

  always #10 clk = ~clk;

  fr_sched #(.NB(NB), .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W),
             .WR_HI(WR_HI), .WR_LO(WR_LO)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_wr_i(req_wr),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .bank_busy_i(busy), .row_open_i(ropen), .open_row_i(orow),
    .iss_valid_o(iss_valid), .iss_ready_i(iss_ready), .iss_wr_o(iss_wr),
    .iss_bank_o(iss_bank), .iss_row_o(iss_row), .iss_col_o(iss_col));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_vld[CAP], m_wr[CAP], m_bank[CAP], m_row[CAP], m_col[CAP], m_seq[CAP];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1..watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seq = 0;
    bit drain_m = 0;
    bit prev_hold = 0;
    mode = 0; req_valid = 0; req_wr = 0; req_bank = 0; req_row = 0; req_col = 0;
    busy = '0; ropen = '0; orow = '0; iss_ready = 0;
    for (int i = 0; i < CAP; i++) m_vld[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    for (int b = 0; b < NB; b++) begin
      req_bank = 2'(b); #1;
      chk(req_ready === 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    end
    chk(iss_valid === 1'b0, "R1", "iss_valid after reset", int'(iss_valid), 0);

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      int rdn, wrn, bcnt, bi, bhit, bseq;
      bit pref, found, ev, erdy, older_miss, older_busy;
      string tag;
      @(negedge clk);
      if (cyc % 200 == 0) mode = $urandom_range(0, 1);
      busy = 4'($urandom) & 4'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        int b = $urandom_range(0, NB - 1);
        ropen[b] = $urandom_range(0, 3) != 0;
        orow[b*ROW_W +: ROW_W] = 2'($urandom);
      end
      req_valid = $urandom_range(0, 9) < 6;
      req_wr    = $urandom_range(0, 1);
      req_bank  = 2'($urandom);
      req_row   = $urandom_range(0, 1) ? orow[int'(req_bank)*ROW_W +: ROW_W] : 2'($urandom);
      req_col   = 3'($urandom);
      iss_ready = $urandom_range(0, 3) != 0;
      #2;
      // expected selection from the requirements
      rdn = 0; wrn = 0; bcnt = 0;
      for (int i = 0; i < CAP; i++) if (m_vld[i]) begin
        if (m_wr[i] != 0) wrn++; else rdn++;
        if (m_bank[i] == int'(req_bank)) bcnt++;
      end
      pref = drain_m || rdn == 0;
      found = 0; bi = 0; bhit = 0; bseq = 0;
      for (int i = 0; i < CAP; i++) begin
        int h;
        if (m_vld[i] && (m_wr[i] != 0) == pref && !(mode && busy[m_bank[i]])) begin
          h = (mode && ropen[m_bank[i]] &&
               int'(orow[m_bank[i]*ROW_W +: ROW_W]) == m_row[i]) ? 1 : 0;
          if (!found || h > bhit || (h == bhit && m_seq[i] < bseq)) begin
            found = 1; bi = i; bhit = h; bseq = m_seq[i];
          end
        end
      end
      ev = found && !busy[m_bank[bi]];
      older_miss = 0; older_busy = 0;
      for (int i = 0; i < CAP; i++) if (found && m_vld[i] && (m_wr[i] != 0) == pref && m_seq[i] < bseq) begin
        if (busy[m_bank[i]]) older_busy = 1; else older_miss = 1;
      end
      if (prev_hold) tag = "R9";
      else if (drain_m) tag = "R8";
      else if (rdn > 0 && wrn > 0) tag = "R7";
      else if (!mode) tag = "R3";
      else if (bhit == 1 && older_miss) tag = "R4";
      else if (older_busy) tag = "R6";
      else tag = "R5";
      chk(iss_valid === ev, tag, "iss_valid", int'(iss_valid), int'(ev));
      if (ev && iss_valid === 1'b1) begin
        chk(int'(iss_bank) == m_bank[bi] && int'(iss_row) == m_row[bi] &&
            int'(iss_col) == m_col[bi] && int'(iss_wr) == m_wr[bi],
            "R10", "iss fields {bank,row,col,wr}",
            {int'(iss_bank), 8'(iss_row), 8'(iss_col), 8'(iss_wr)},
            {m_bank[bi], 8'(m_row[bi]), 8'(m_col[bi]), 8'(m_wr[bi])});
      end
      erdy = bcnt < DEPTH;
      chk(req_ready === erdy, "R2", "req_ready", int'(req_ready), int'(erdy));
      @(posedge clk);
      // model update with this cycle's handshakes
      prev_hold = ev && !iss_ready;
      if (ev && iss_ready) m_vld[bi] = 0;
      if (req_valid && erdy) begin
        for (int i = 0; i < CAP; i++) if (!m_vld[i]) begin
          m_vld[i] = 1; m_wr[i] = int'(req_wr); m_bank[i] = int'(req_bank);
          m_row[i] = int'(req_row); m_col[i] = int'(req_col); m_seq[i] = seq;
          break;
        end
        seq++;
      end
      wrn = 0;
      for (int i = 0; i < CAP; i++) if (m_vld[i] && m_wr[i] != 0) wrn++;
      if (wrn >= WR_HI) drain_m = 1;
      else if (wrn < WR_LO) drain_m = 0;
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule